// File: doc/BRIEF.md
# Configurable Branch Direction and Target Predictor

This block predicts, for a machine with a 16-bit program counter, whether a branch will be taken and where it will go. A mode register, writable at run time, chooses one of four prediction schemes: off (always fall through), PC-indexed 2-bit counters, local-history counters (a small table of per-branch histories whose value selects a counter), or a static rule that predicts backward branches taken. A branch target buffer supplies the predicted target in every mode except off.

The fetch side presents the PC and the branch's 7-bit signed offset field on the prediction port. The block answers in the same cycle, combinationally from its current state. It returns the direction, the target, and each table index it used. Each index comes with a valid bit that is cleared when the mode did not use that table. Once the branch resolves, the pipeline returns those indices on the update port, along with the real direction and target. The tables change at the next clock edge. A prediction in the same cycle as an update still sees the old contents.

Top module: `brpred_core`

## Requirements
- R1: Synchronous active-low reset sets the mode to local-history (code 2), every history to 0, every counter to 1 and every target entry to 0.
- R2: In local-history mode the history index is PC[1:0] (valid) and the counter index is the 4-bit history stored there (valid).
- R3: In PC-indexed mode the counter index is PC[3:0] (valid) and the history index is reported invalid with value 0.
- R4: In PC-indexed and local-history modes, taken is predicted exactly when bit 1 of the selected counter is set.
- R5: An accepted counter update adds one on taken and subtracts one on not-taken, staying within 0 to 3 without wrapping.
- R6: An accepted history update shifts the 4-bit history left by one and places the resolved direction in bit 0.
- R7: The target index is PC[1:0] (valid) in every mode except off. The predicted target is that entry. An accepted target update writes the resolved target there.
- R8: In static mode, taken is predicted exactly when the 7-bit offset is negative (bit 6 set). Only the target index is valid.
- R9: In off mode (code 0), the prediction is not taken, the target is PC+1 modulo 2^16, and all index valid bits are clear. Updates change no table.
- R10: An update whose index valid bit is clear leaves the table that index belongs to unchanged.
- R11: Asserting mode_wr loads mode_wdata into the mode register at the clock edge. Codes: 0 off, 1 PC-indexed, 2 local-history, 3 static.
- R12: Histories change only in local-history mode. Counters change only in PC-indexed and local-history modes. Index values that are not valid are driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Load the mode register |
| mode_wdata | input | 2 | New mode code |
| mode_cur | output | 2 | Current mode code |
| pred_pc | input | 16 | PC of the branch being predicted |
| pred_ofs | input | 7 | Signed offset field of that branch |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 16 | Predicted target |
| pred_hidx | output | 2 | History table index used |
| pred_hidx_vld | output | 1 | History index is meaningful |
| pred_pidx | output | 4 | Counter table index used |
| pred_pidx_vld | output | 1 | Counter index is meaningful |
| pred_tidx | output | 2 | Target buffer index used |
| pred_tidx_vld | output | 1 | Target index is meaningful |
| upd_en | input | 1 | Resolved branch update strobe |
| upd_hidx | input | 2 | History index returned from prediction |
| upd_hidx_vld | input | 1 | History index valid |
| upd_pidx | input | 4 | Counter index returned from prediction |
| upd_pidx_vld | input | 1 | Counter index valid |
| upd_tidx | input | 2 | Target index returned from prediction |
| upd_tidx_vld | input | 1 | Target index valid |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 16 | Resolved target |

## Verification
Assertions check on every cycle that:
- off mode stays quiet and static mode follows the offset sign;
- a mode write lands;
- a history shifts in the resolved bit;
- counters hold at their limits;
- target writes land;
- each table holds its contents whenever its write enable is low.

Some behaviours need whole scenarios in the bench, because they depend on a chain of updates followed by a later prediction: how a trained history steers the counter lookup, the exact saturation sequence, the gating of updates by mode, and whether tables written in one mode still hold their contents after a switch to another.

// File: rtl/brpred_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the branch predictor: the mode encoding.
package brpred_pkg;
    typedef enum logic [1:0] {
        BP_OFF       = 2'd0,  // never taken, target PC+1
        BP_PCIDX     = 2'd1,  // counters indexed by the PC
        BP_LOCHIST   = 2'd2,  // counters indexed by a per-branch history
        BP_BACKTAKEN = 2'd3   // taken when the offset is negative
    } bp_mode_e;
endpackage

// File: rtl/brpred_hist_tbl.sv
`timescale 1ns/1ps
// Per-branch history table. Each entry is a HIST_W-bit shift register of
// resolved directions, newest in bit 0. Assumes ENTRIES is a power of two
// and HIST_W >= 2. One read port (combinational), one write port.
module brpred_hist_tbl #(
    parameter int ENTRIES = 4,
    parameter int HIST_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    logic [ENTRIES-1:0][HIST_W-1:0] hist_q;

    // Read the addressed history.
    assign rd_hist = hist_q[rd_idx];

    // Clear on reset; shift the resolved direction into the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= {hist_q[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (hist_q[$past(wr_idx)][HIST_W-1:1] == $past(hist_q[wr_idx][HIST_W-2:0]))
                  && (hist_q[$past(wr_idx)][0] == $past(wr_bit)));

    assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist_q));
endmodule

// File: rtl/brpred_ctr_tbl.sv
`timescale 1ns/1ps
// Pattern table of saturating up/down counters. The prediction is the
// counter MSB. Assumes ENTRIES is a power of two; INIT fits in CNT_W bits.
module brpred_ctr_tbl #(
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 2,
    parameter int INIT    = 1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT);

    logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0]              wr_cur;

    // Counter MSB gives the direction.
    assign rd_taken = cnt_q[rd_idx][CNT_W-1];
    // Current value of the entry being trained.
    assign wr_cur   = cnt_q[wr_idx];

    // Reset to the weak value; step toward the outcome, clamped at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CNT_INIT;
        end else if (wr_en) begin
            if (wr_up && wr_cur != CNT_MAX)
                cnt_q[wr_idx] <= wr_cur + CNT_W'(1);
            else if (!wr_up && wr_cur != '0)
                cnt_q[wr_idx] <= wr_cur - CNT_W'(1);
        end
    end

    assert_ctr_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && wr_cur == CNT_MAX) |=> cnt_q[$past(wr_idx)] == CNT_MAX);

    assert_ctr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && wr_cur == '0) |=> cnt_q[$past(wr_idx)] == '0);

    assert_ctr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_q));
endmodule

// File: rtl/brpred_tgt_buf.sv
`timescale 1ns/1ps
// Branch target buffer: direct-mapped, untagged, one target per entry.
// Assumes ENTRIES is a power of two.
module brpred_tgt_buf #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tgt
);
    logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;

    // Read the addressed target.
    assign rd_tgt = tgt_q[rd_idx];

    // Clear on reset; store the resolved target.
    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else if (wr_en) tgt_q[wr_idx] <= wr_tgt;
    end

    assert_tgt_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tgt_q[$past(wr_idx)] == $past(wr_tgt));

    assert_tgt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tgt_q));
endmodule

// File: rtl/brpred_core.sv
`timescale 1ns/1ps
// Configurable branch direction and target predictor. The prediction is
// combinational from current state; updates take effect at the next edge.
// Assumes the update port returns indices produced by the prediction port.
// Tables: HIST_ENTRIES histories of HIST_W bits, 2**HIST_W counters,
// TGT_ENTRIES targets.
module brpred_core
    import brpred_pkg::*;
#(
    parameter int       PC_W         = 16,
    parameter int       OFS_W        = 7,
    parameter int       HIST_ENTRIES = 4,
    parameter int       HIST_W       = 4,
    parameter int       TGT_ENTRIES  = 4,
    parameter int       CNT_W        = 2,
    parameter bp_mode_e RESET_MODE   = BP_LOCHIST,
    localparam int      HIDX_W       = $clog2(HIST_ENTRIES),
    localparam int      PIDX_W       = HIST_W,
    localparam int      TIDX_W       = $clog2(TGT_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_cur,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic [OFS_W-1:0]  pred_ofs,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_target,
    output logic [HIDX_W-1:0] pred_hidx,
    output logic              pred_hidx_vld,
    output logic [PIDX_W-1:0] pred_pidx,
    output logic              pred_pidx_vld,
    output logic [TIDX_W-1:0] pred_tidx,
    output logic              pred_tidx_vld,
    input  logic              upd_en,
    input  logic [HIDX_W-1:0] upd_hidx,
    input  logic              upd_hidx_vld,
    input  logic [PIDX_W-1:0] upd_pidx,
    input  logic              upd_pidx_vld,
    input  logic [TIDX_W-1:0] upd_tidx,
    input  logic              upd_tidx_vld,
    input  logic              upd_taken,
    input  logic [PC_W-1:0]   upd_target
);
    localparam int PAT_ENTRIES = 1 << HIST_W;

    bp_mode_e          mode_q;
    logic [HIDX_W-1:0] pc_hidx;
    logic [TIDX_W-1:0] pc_tidx;
    logic [HIST_W-1:0] hist_rd;
    logic [PIDX_W-1:0] pidx_sel;
    logic              ctr_taken;
    logic [PC_W-1:0]   tgt_rd;
    logic              hist_we, ctr_we, tgt_we;

    // Mode register: reset value from RESET_MODE, loaded on mode_wr.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RESET_MODE;
        else if (mode_wr) mode_q <= bp_mode_e'(mode_wdata);
    end
    assign mode_cur = mode_q;

    // Table addresses derived from the PC and, in local-history mode, the history.
    assign pc_hidx  = pred_pc[HIDX_W-1:0];
    assign pc_tidx  = pred_pc[TIDX_W-1:0];
    assign pidx_sel = (mode_q == BP_LOCHIST) ? hist_rd : pred_pc[PIDX_W-1:0];

    // Update gating: each table is written only in the modes that own it.
    assign hist_we = upd_en && upd_hidx_vld && (mode_q == BP_LOCHIST);
    assign ctr_we  = upd_en && upd_pidx_vld &&
                     (mode_q == BP_LOCHIST || mode_q == BP_PCIDX);
    assign tgt_we  = upd_en && upd_tidx_vld && (mode_q != BP_OFF);

    brpred_hist_tbl #(.ENTRIES(HIST_ENTRIES), .HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pc_hidx), .rd_hist(hist_rd),
        .wr_en(hist_we), .wr_idx(upd_hidx), .wr_bit(upd_taken)
    );

    brpred_ctr_tbl #(.ENTRIES(PAT_ENTRIES), .CNT_W(CNT_W), .INIT(1)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pidx_sel), .rd_taken(ctr_taken),
        .wr_en(ctr_we), .wr_idx(upd_pidx), .wr_up(upd_taken)
    );

    brpred_tgt_buf #(.ENTRIES(TGT_ENTRIES), .ADDR_W(PC_W)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pc_tidx), .rd_tgt(tgt_rd),
        .wr_en(tgt_we), .wr_idx(upd_tidx), .wr_tgt(upd_target)
    );

    // Assemble the prediction for the current mode; unused indices read 0.
    always_comb begin
        pred_taken    = 1'b0;
        pred_target   = pred_pc + PC_W'(1);
        pred_hidx     = '0;
        pred_hidx_vld = 1'b0;
        pred_pidx     = '0;
        pred_pidx_vld = 1'b0;
        pred_tidx     = '0;
        pred_tidx_vld = 1'b0;
        case (mode_q)
            BP_PCIDX, BP_LOCHIST: begin
                pred_pidx     = pidx_sel;
                pred_pidx_vld = 1'b1;
                pred_taken    = ctr_taken;
                pred_tidx     = pc_tidx;
                pred_tidx_vld = 1'b1;
                pred_target   = tgt_rd;
                if (mode_q == BP_LOCHIST) begin
                    pred_hidx     = pc_hidx;
                    pred_hidx_vld = 1'b1;
                end
            end
            BP_BACKTAKEN: begin
                pred_taken    = $signed(pred_ofs) < 0;
                pred_tidx     = pc_tidx;
                pred_tidx_vld = 1'b1;
                pred_target   = tgt_rd;
            end
            default: ;
        endcase
    end

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == 2'd0) |-> (!pred_taken && pred_target == pred_pc + PC_W'(1)
                                && !pred_hidx_vld && !pred_pidx_vld && !pred_tidx_vld));

    assert_static_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == 2'd3) |-> (pred_taken == pred_ofs[OFS_W-1]
                                && !pred_pidx_vld && !pred_hidx_vld && pred_tidx_vld));

    assert_mode_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_cur == $past(mode_wdata));
endmodule

// File: tb/brpred_core_bench.sv
`timescale 1ns/1ps
module brpred_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic [1:0]  mode_cur;
    logic [15:0] pred_pc = '0;
    logic [6:0]  pred_ofs = '0;
    logic        pred_taken;
    logic [15:0] pred_target;
    logic [1:0]  pred_hidx;
    logic        pred_hidx_vld;
    logic [3:0]  pred_pidx;
    logic        pred_pidx_vld;
    logic [1:0]  pred_tidx;
    logic        pred_tidx_vld;
    logic        upd_en = 1'b0;
    logic [1:0]  upd_hidx = '0;
    logic        upd_hidx_vld = 1'b0;
    logic [3:0]  upd_pidx = '0;
    logic        upd_pidx_vld = 1'b0;
    logic [1:0]  upd_tidx = '0;
    logic        upd_tidx_vld = 1'b0;
    logic        upd_taken = 1'b0;
    logic [15:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [3:0]  m_hist [4];
    logic [1:0]  m_ctr  [16];
    logic [15:0] m_tgt  [4];
    logic [1:0]  m_mode;

    always #10 clk = ~clk;  // 50 MHz

    brpred_core u_brpred_core (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_cur(mode_cur), .pred_pc(pred_pc), .pred_ofs(pred_ofs),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .pred_hidx(pred_hidx), .pred_hidx_vld(pred_hidx_vld),
        .pred_pidx(pred_pidx), .pred_pidx_vld(pred_pidx_vld),
        .pred_tidx(pred_tidx), .pred_tidx_vld(pred_tidx_vld),
        .upd_en(upd_en), .upd_hidx(upd_hidx), .upd_hidx_vld(upd_hidx_vld),
        .upd_pidx(upd_pidx), .upd_pidx_vld(upd_pidx_vld),
        .upd_tidx(upd_tidx), .upd_tidx_vld(upd_tidx_vld),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Prediction packed as {taken, target, hv, hidx, pv, pidx, tv, tidx}.
    function automatic logic [27:0] model_pred(input logic [15:0] pc, input logic [6:0] ofs);
        logic [3:0] pi;
        case (m_mode)
            2'd1: begin
                pi = pc[3:0];
                return {m_ctr[pi][1], m_tgt[pc[1:0]], 1'b0, 2'b00, 1'b1, pi, 1'b1, pc[1:0]};
            end
            2'd2: begin
                pi = m_hist[pc[1:0]];
                return {m_ctr[pi][1], m_tgt[pc[1:0]], 1'b1, pc[1:0], 1'b1, pi, 1'b1, pc[1:0]};
            end
            2'd3: return {ofs[6], m_tgt[pc[1:0]], 1'b0, 2'b00, 1'b0, 4'h0, 1'b1, pc[1:0]};
            default: return {1'b0, pc + 16'd1, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 2'b00};
        endcase
    endfunction

    function automatic logic [27:0] dut_pred();
        return {pred_taken, pred_target, pred_hidx_vld, pred_hidx,
                pred_pidx_vld, pred_pidx, pred_tidx_vld, pred_tidx};
    endfunction

    task automatic probe(input string req, input logic [15:0] pc, input logic [6:0] ofs);
        @(negedge clk);
        pred_pc = pc; pred_ofs = ofs;
        #1;
        check(req, 32'(dut_pred()), 32'(model_pred(pc, ofs)));
    endtask

    // Drive one update with explicit index fields; mirror it in the model.
    task automatic raw_update(input logic hv, input logic [1:0] hi, input logic pv,
                              input logic [3:0] pi, input logic tv, input logic [1:0] ti,
                              input logic tk, input logic [15:0] tg);
        @(negedge clk);
        upd_en = 1'b1; upd_hidx_vld = hv; upd_hidx = hi; upd_pidx_vld = pv;
        upd_pidx = pi; upd_tidx_vld = tv; upd_tidx = ti; upd_taken = tk; upd_target = tg;
        @(posedge clk);
        if (hv && m_mode == 2'd2) m_hist[hi] = {m_hist[hi][2:0], tk};
        if (pv && (m_mode == 2'd1 || m_mode == 2'd2)) begin
            if (tk && m_ctr[pi] != 2'd3) m_ctr[pi] = m_ctr[pi] + 2'd1;
            else if (!tk && m_ctr[pi] != 2'd0) m_ctr[pi] = m_ctr[pi] - 2'd1;
        end
        if (tv && m_mode != 2'd0) m_tgt[ti] = tg;
        #1 upd_en = 1'b0;
    endtask

    // Predict a branch, then return the indices the block reported.
    task automatic resolve(input logic [15:0] pc, input logic tk, input logic [15:0] tg);
        logic [27:0] p;
        @(negedge clk);
        pred_pc = pc; pred_ofs = 7'h01;
        #1 p = dut_pred();
        raw_update(p[10], p[9:8], p[7], p[6:3], p[2], p[1:0], tk, tg);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(posedge clk);
        #1 mode_wr = 1'b0;
        m_mode = m;
        check("R11 mode load", 32'(mode_cur), 32'(m));
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin m_hist[i] = '0; m_tgt[i] = '0; end
        for (int i = 0; i < 16; i++) m_ctr[i] = 2'd1;
        m_mode = 2'd2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset mode", 32'(mode_cur), 32'd2);
        probe("R1 reset tables pc=5", 16'h0005, 7'h00);
        check("R1 reset not taken", 32'(pred_taken), 32'd0);
        check("R1 reset target zero", 32'(pred_target), 32'd0);
    endtask

    task automatic t_local_history();
        // Train pc=1 taken four times: history 1111 selects counter 15.
        for (int i = 0; i < 4; i++) resolve(16'h0001, 1'b1, 16'h0040);
        probe("R2 history selects counter", 16'h0001, 7'h00);
        check("R6 history 1111 -> pidx", 32'(pred_pidx), 32'hF);
        check("R2 hidx from pc", 32'(pred_hidx), 32'd1);
        resolve(16'h0001, 1'b0, 16'h0040);
        probe("R6 shift in zero", 16'h0001, 7'h00);
        check("R6 history 1110 -> pidx", 32'(pred_pidx), 32'hE);
        probe("R2 other branch untouched", 16'h0002, 7'h00);
        check("R2 pc=2 pidx still 0", 32'(pred_pidx), 32'd0);
    endtask

    task automatic t_saturation();
        set_mode(2'd1);
        for (int i = 0; i < 3; i++) raw_update(0, 0, 1, 4'h5, 0, 0, 1'b1, 16'h0);
        probe("R5 saturate high", 16'h0005, 7'h00);
        check("R4 counter 3 taken", 32'(pred_taken), 32'd1);
        for (int i = 0; i < 5; i++) raw_update(0, 0, 1, 4'h5, 0, 0, 1'b0, 16'h0);
        raw_update(0, 0, 1, 4'h5, 0, 0, 1'b1, 16'h0);
        probe("R5 floor then up", 16'h0005, 7'h00);
        check("R5 counter 1 not taken", 32'(pred_taken), 32'd0);
        raw_update(0, 0, 1, 4'h5, 0, 0, 1'b1, 16'h0);
        probe("R4 counter 2", 16'h0005, 7'h00);
        check("R4 counter 2 taken", 32'(pred_taken), 32'd1);
        probe("R3 pc-indexed fields", 16'h0123, 7'h00);
        check("R3 pidx pc[3:0]", 32'(pred_pidx), 32'h3);
        check("R3 hidx invalid", 32'({pred_hidx_vld, pred_hidx}), 32'd0);
        resolve(16'h0002, 1'b1, 16'h0000);  // must not touch history (R12)
    endtask

    task automatic t_static();
        set_mode(2'd3);
        probe("R8 offset -64", 16'h0010, 7'h40);
        check("R8 negative taken", 32'(pred_taken), 32'd1);
        probe("R8 offset +63", 16'h0010, 7'h3F);
        check("R8 positive not taken", 32'(pred_taken), 32'd0);
        probe("R8 offset -1", 16'h0011, 7'h7F);
        resolve(16'h0003, 1'b1, 16'hBEEF);  // target written, counters not (R12)
        probe("R7 static reads target", 16'h0007, 7'h00);
        check("R7 target entry 3", 32'(pred_target), 32'hBEEF);
    endtask

    task automatic t_off();
        set_mode(2'd0);
        probe("R9 off fall-through", 16'h1234, 7'h40);
        probe("R9 off wraps", 16'hFFFF, 7'h7F);
        check("R9 target wraps to 0", 32'(pred_target), 32'd0);
        raw_update(1, 2'd2, 1, 4'h2, 1, 2'd2, 1'b1, 16'h1111);
        set_mode(2'd1);
        probe("R9 off updates ignored ctr/tgt", 16'h0002, 7'h00);
        check("R9 target unchanged", 32'(pred_target), 32'd0);
        set_mode(2'd2);
        probe("R12 history untouched", 16'h0002, 7'h00);
        check("R12 pc=2 history still 0", 32'(pred_pidx), 32'd0);
    endtask

    task automatic t_invalid_index();
        raw_update(0, 2'd0, 0, 4'h0, 0, 2'd0, 1'b1, 16'h7777);
        probe("R10 no-valid update ignored", 16'h0000, 7'h00);
        check("R10 target 0 unchanged", 32'(pred_target), 32'd0);
        raw_update(1, 2'd0, 0, 4'h0, 1, 2'd0, 1'b1, 16'h2222);
        probe("R10 only valid tables move", 16'h0000, 7'h00);
        check("R10 history moved to 0001", 32'(pred_pidx), 32'd1);
        set_mode(2'd1);
        probe("R10 counter 0 unchanged", 16'h0000, 7'h00);
        check("R7 target 0 written", 32'(pred_target), 32'h2222);
        probe("R12 static left counter 3", 16'h0003, 7'h00);
    endtask

    initial begin
        t_reset();
        t_local_history();
        t_saturation();
        t_static();
        t_off();
        t_invalid_index();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule